// File: doc/BRIEF.md
# Leaf Page-Entry Access Judge

This block decides whether a leaf page-table entry allows a requested memory access. A requester presents a 64-bit entry with three request attributes (privileged mode, instruction fetch, store) and pulses a valid strobe. One clock later the block returns one of three outcomes:

- a grant, meaning the translation may be installed;
- a permission error;
- a reference/change error.

A permission failure always hides a reference/change failure. The outcome is held on the result pins until the next strobe.

The request side is a plain valid strobe with no ready. The block accepts one request on every cycle and never applies back-pressure. The result side is a one-cycle valid pulse with no ready either. A consumer that needs the outcome later can read the held result flags.

Bit positions below use bit 0 as the least significant bit of the entry.

Top module: `pte_access_judge`

## Requirements
- R1: While reset is asserted and after its release, res_valid, res_grant, res_perm_err and res_rc_err are all low until the first strobe is registered.
- R2: A request strobed on a clock edge produces res_valid high for exactly the following cycle, with the outcome flags updated at that same edge.
- R3: When req_priv is low and entry bit 3 (supervisor-only) is set, the outcome is a permission error whatever the other bits are.
- R4: For a data access (req_iside low), permission holds when bit 1 (read) is set, or when bit 2 (write) is set and req_store is low.
- R5: For an instruction fetch (req_iside high), permission holds only when bit 0 (execute) is set and bit 5 (uncached attribute) is clear.
- R6: An entry with bit 62 (leaf) clear yields a permission error and no grant.
- R7: The reference/change check passes when bit 8 (referenced) is set and either bit 7 (changed) is set or req_store is low. When permission holds and this check fails, the outcome is a reference/change error. When both hold, the outcome is a grant.
- R8: Exactly one of res_grant, res_perm_err and res_rc_err is high whenever res_valid is high, and a permission failure takes precedence over a reference/change failure.
- R9: On cycles without a strobe, the entry and attribute inputs are ignored and the outcome flags keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; the inputs below are sampled on it |
| req_pte | input | 64 | Leaf page-table entry under test |
| req_priv | input | 1 | Requester runs privileged |
| req_iside | input | 1 | Access is an instruction fetch |
| req_store | input | 1 | Access is a store |
| res_valid | output | 1 | One-cycle pulse marking a new outcome |
| res_grant | output | 1 | Access allowed (held) |
| res_perm_err | output | 1 | Permission fault (held) |
| res_rc_err | output | 1 | Reference/change fault (held) |

## Verification
The assertions assume that req_valid and the request fields are driven to known values from reset onward. They also assume that the entry seen on a strobe cycle is the one the outcome should describe.

The checks that compare the past inputs of a strobe with the present outcome rely on the request fields staying defined during reset. The bench keeps every input at zero until reset is released. From then on it changes inputs only on the falling clock edge.

Random entries are biased so that the leaf, read, write, execute, referenced and changed bits each take both values often. Garbage values on idle cycles exercise the rule that inputs are ignored without a strobe.

// File: rtl/pte_judge_pkg.sv
package pte_judge_pkg;
  localparam int unsigned PTE_W = 64;

  // Entry bit positions (bit 0 is the least significant bit)
  localparam int unsigned B_EXEC    = 0;
  localparam int unsigned B_READ    = 1;
  localparam int unsigned B_WRITE   = 2;
  localparam int unsigned B_SUPER   = 3;
  localparam int unsigned B_NOCACHE = 5;
  localparam int unsigned B_CHANGED = 7;
  localparam int unsigned B_REFD    = 8;
  localparam int unsigned B_LEAF    = 62;

  typedef enum logic [1:0] {
    VERD_NONE  = 2'd0,
    VERD_GRANT = 2'd1,
    VERD_PERM  = 2'd2,
    VERD_RC    = 2'd3
  } verdict_e;

  typedef struct packed {
    logic priv;
    logic iside;
    logic store;
  } req_attr_t;
endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
  import pte_judge_pkg::*;
#(
  parameter int unsigned W               = PTE_W,
  parameter bit          NOEXEC_UNCACHED = 1'b1
) (
  input  logic [W-1:0] pte,
  input  req_attr_t    attr,
  output logic         perm_ok
);
  logic is_leaf;
  logic mode_ok;
  logic data_ok;
  logic fetch_ok;

  assign is_leaf = pte[B_LEAF];
  assign mode_ok = attr.priv | ~pte[B_SUPER];
  assign data_ok = pte[B_READ] | (pte[B_WRITE] & ~attr.store);

  generate
    if (NOEXEC_UNCACHED) begin : g_fetch_strict
      assign fetch_ok = pte[B_EXEC] & ~pte[B_NOCACHE];
    end else begin : g_fetch_plain
      assign fetch_ok = pte[B_EXEC];
    end
  endgenerate

  assign perm_ok = is_leaf & mode_ok & (attr.iside ? fetch_ok : data_ok);
endmodule

// File: rtl/pte_rc_eval.sv
module pte_rc_eval
  import pte_judge_pkg::*;
#(
  parameter int unsigned W = PTE_W
) (
  input  logic [W-1:0] pte,
  input  logic         store,
  output logic         rc_ok
);
  assign rc_ok = pte[B_REFD] & (pte[B_CHANGED] | ~store);
endmodule

// File: rtl/pte_verdict_reg.sv
module pte_verdict_reg
  import pte_judge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic perm_ok,
  input  logic rc_ok,
  output logic vld,
  output logic grant,
  output logic perm_err,
  output logic rc_err
);
  verdict_e verd_d;
  verdict_e verd_q;

  always_comb begin
    if (!perm_ok)      verd_d = VERD_PERM;
    else if (!rc_ok)   verd_d = VERD_RC;
    else               verd_d = VERD_GRANT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verd_q <= VERD_NONE;
      vld    <= 1'b0;
    end else begin
      vld <= take;
      if (take) verd_q <= verd_d;
    end
  end

  assign grant    = (verd_q == VERD_GRANT);
  assign perm_err = (verd_q == VERD_PERM);
  assign rc_err   = (verd_q == VERD_RC);

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $countones({grant, perm_err, rc_err}) == 1);

  assert_perm_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take) && !$past(perm_ok) |-> perm_err && !rc_err);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(take) |-> $stable({grant, perm_err, rc_err}));

  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> vld == $past(take, 1));
endmodule

// File: rtl/pte_access_judge.sv
module pte_access_judge
  import pte_judge_pkg::*;
#(
  parameter int unsigned W               = PTE_W,
  parameter bit          NOEXEC_UNCACHED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [W-1:0] req_pte,
  input  logic         req_priv,
  input  logic         req_iside,
  input  logic         req_store,
  output logic         res_valid,
  output logic         res_grant,
  output logic         res_perm_err,
  output logic         res_rc_err
);
  req_attr_t attr;
  logic      perm_ok;
  logic      rc_ok;

  assign attr = '{priv: req_priv, iside: req_iside, store: req_store};

  pte_perm_eval #(.W(W), .NOEXEC_UNCACHED(NOEXEC_UNCACHED)) u_perm (
    .pte     (req_pte),
    .attr    (attr),
    .perm_ok (perm_ok)
  );

  pte_rc_eval #(.W(W)) u_rc (
    .pte   (req_pte),
    .store (req_store),
    .rc_ok (rc_ok)
  );

  pte_verdict_reg u_verd (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (req_valid),
    .perm_ok  (perm_ok),
    .rc_ok    (rc_ok),
    .vld      (res_valid),
    .grant    (res_grant),
    .perm_err (res_perm_err),
    .rc_err   (res_rc_err)
  );

  assert_nonleaf_denied_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid) && !$past(req_pte[B_LEAF]) |-> res_perm_err && !res_grant);

  assert_user_on_super_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid) && !$past(req_priv) && $past(req_pte[B_SUPER]) |-> res_perm_err);

  assert_uncached_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid) && $past(req_iside) && $past(req_pte[B_NOCACHE])
      && NOEXEC_UNCACHED |-> !res_grant && !res_rc_err);

  assert_rc_needs_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid) && !$past(req_pte[B_REFD]) |-> !res_grant);
endmodule

// File: tb/pte_access_judge_tb.sv
module pte_access_judge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_pte = '0;
  logic        req_priv = 1'b0;
  logic        req_iside = 1'b0;
  logic        req_store = 1'b0;
  logic        res_valid, res_grant, res_perm_err, res_rc_err;

  int n_vec = 0;
  int n_bad = 0;
  logic [2:0] last_exp = 3'b000;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pte_access_judge dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pte(req_pte),
    .req_priv(req_priv), .req_iside(req_iside), .req_store(req_store),
    .res_valid(res_valid), .res_grant(res_grant),
    .res_perm_err(res_perm_err), .res_rc_err(res_rc_err)
  );

  // returns {grant, perm_err, rc_err}
  function automatic logic [2:0] expect_of(input logic [63:0] p, input logic pv,
                                           input logic is, input logic st);
    logic perm, rc;
    perm = 1'b0;
    if (p[62] && (pv || !p[3]))
      perm = is ? (p[0] && !p[5]) : (p[1] || (p[2] && !st));
    rc = p[8] && (p[7] || !st);
    return {perm && rc, !perm, perm && !rc};
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {valid,grant,perm,rc} actual %b expected %b", tag, got, exp);
    end
  endtask

  // Strobe one request, check the pulse cycle, then an idle cycle with garbage
  task automatic apply(input string tag, input logic [63:0] p, input logic pv,
                       input logic is, input logic st);
    logic [2:0] e;
    e = expect_of(p, pv, is, st);
    @(negedge clk);
    req_valid = 1'b1; req_pte = p; req_priv = pv; req_iside = is; req_store = st;
    @(negedge clk);
    check({tag, " R2"}, {res_valid, res_grant, res_perm_err, res_rc_err}, {1'b1, e});
    req_valid = 1'b0; req_pte = ~p; req_priv = ~pv; req_iside = ~is; req_store = ~st;
    last_exp = e;
    @(negedge clk);
    check("R9 hold", {res_valid, res_grant, res_perm_err, res_rc_err}, {1'b0, last_exp});
  endtask

  function automatic logic [63:0] mk(input logic leaf, input logic sup, input logic ex,
                                     input logic rd, input logic wr, input logic nc,
                                     input logic chg, input logic refd);
    logic [63:0] v;
    v = '0;
    v[62] = leaf; v[3] = sup; v[0] = ex; v[1] = rd; v[2] = wr;
    v[5] = nc; v[7] = chg; v[8] = refd;
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] p;
    void'($urandom(32'd20211));
    repeat (3) @(negedge clk);
    check("R1 in reset", {res_valid, res_grant, res_perm_err, res_rc_err}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {res_valid, res_grant, res_perm_err, res_rc_err}, 4'b0000);

    apply("R4 read load",       mk(1,0,0,1,0,0,0,1), 0, 0, 0);
    apply("R4 write-only load", mk(1,0,0,0,1,0,0,1), 0, 0, 0);
    apply("R4 write-only store",mk(1,0,0,0,1,0,1,1), 0, 0, 1);
    apply("R4 no rights",       mk(1,0,1,0,0,0,1,1), 1, 0, 0);
    apply("R3 user on super",   mk(1,1,1,1,1,0,1,1), 0, 0, 0);
    apply("R3 priv on super",   mk(1,1,0,1,0,0,1,1), 1, 0, 1);
    apply("R5 fetch ok",        mk(1,0,1,0,0,0,0,1), 0, 1, 0);
    apply("R5 fetch uncached",  mk(1,0,1,1,1,1,1,1), 1, 1, 0);
    apply("R5 fetch no exec",   mk(1,0,0,1,1,0,1,1), 0, 1, 0);
    apply("R6 non-leaf",        mk(0,0,1,1,1,0,1,1), 1, 0, 0);
    apply("R7 store unchanged", mk(1,0,0,1,0,0,0,1), 0, 0, 1);
    apply("R7 unreferenced",    mk(1,0,0,1,0,0,1,0), 0, 0, 0);
    apply("R8 both fail",       mk(1,1,0,1,0,0,0,0), 0, 0, 1);

    // back-to-back strobes: each outcome follows its own request (R2)
    @(negedge clk);
    req_valid = 1'b1; req_pte = mk(0,0,0,0,0,0,0,0); req_priv = 1'b1; req_iside = 1'b0; req_store = 1'b0;
    @(negedge clk);
    check("R2 b2b first", {res_valid, res_grant, res_perm_err, res_rc_err}, 4'b1010);
    req_pte = mk(1,0,0,1,0,0,1,1);
    @(negedge clk);
    check("R2 b2b second", {res_valid, res_grant, res_perm_err, res_rc_err}, 4'b1100);
    req_valid = 1'b0;
    @(negedge clk);
    check("R9 hold b2b", {res_valid, res_grant, res_perm_err, res_rc_err}, 4'b0100);

    for (int i = 0; i < 400; i++) begin
      p = {$urandom, $urandom};
      p[62] = ($urandom_range(0, 7) != 0);
      apply((p[62] == 1'b0) ? "R6 rand" : "R7 rand", p,
            1'($urandom), 1'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule